// File: doc/BRIEF.md
# Multi-CPU Level Interrupt Aggregator

This block collects a configurable number of active-high, level-sensitive peripheral interrupt lines and drives one interrupt line per CPU. Each CPU has its own mask register set, so any peripheral line can be routed to any CPU by unmasking it only in that CPU's set. The block has no edge detection, no polarity control, no priority encoder and no event queue. Software finds out which sources are pending by reading every status word in its own window.

Masks never need a read-modify-write. A write-one-to-set word masks lines and a write-one-to-clear word unmasks them, so two CPUs, or two threads on one CPU, cannot lose each other's updates.

The register interface is a simple word-addressed bus with a one-cycle registered read. The upper address bits select the CPU window. The lower bits select a 32-line group and a register within that group. In each group, word offset 0 is status, 1 is set, 2 is clear and 3 is mask. Group `g` occupies word offsets `4g` to `4g+3` of the window. The window spans `2**clog2(4*groups)` words.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every mask bit of every CPU is 1, every `irq_out` bit is 0 and `bus_rdata` is 0.
- R2: A read of a status word (offset 4g) returns, in the cycle after `bus_rd`, bit i = `irq_in[32g+i]` AND NOT mask bit `32g+i` of the addressed CPU, both taken at the read's clock edge. In a cycle after one without `bus_rd`, `bus_rdata` is 0.
- R3: A write to a set word (offset 4g+1) sets the mask bits where the data has a 1. Bits where the data is 0 are left unchanged.
- R4: A write to a clear word (offset 4g+2) clears the mask bits where the data has a 1. Bits where the data is 0 are left unchanged.
- R5: A read of a mask word (offset 4g+3) returns that group's mask. Set and clear words read as 0. Writes to status and mask words change nothing.
- R6: `irq_out[c]` is a register. One cycle after any edge at which some input is high and unmasked for CPU c, it is 1. Otherwise it is 0.
- R7: A write into one CPU's window never changes another CPU's masks.
- R8: Reads of offsets at or above 4×groups, or of a CPU window index at or above the CPU count, return 0. Writes to those addresses change no mask.
- R9: Status is not latched. Once an input drops, a later status read shows the bit as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N_IRQ | Level-sensitive peripheral interrupt lines |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word address: {CPU index, group, register} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd`, else 0 |
| irq_out | output | N_CPU | One registered interrupt line per CPU |

## Verification
A mask bit stuck or written in the wrong CPU bank shows up in two places. It appears on that CPU's `irq_out` one cycle after an input on the bit toggles. It also appears in the next mask or status read of the window. Bad address decoding shows as a nonzero read of a hole or of a missing window, or as masks of a neighbouring CPU changing after a write. Random writes, reads and input levels are checked every cycle against a bench model, so a divergence shows within one cycle of the offending operation being observable.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
   typedef enum logic [1:0] {
      RK_STATUS = 2'd0,
      RK_SET    = 2'd1,
      RK_CLEAR  = 2'd2,
      RK_MASK   = 2'd3
   } reg_kind_e;

   function automatic bit line_count_ok(int n);
      return (n == 64) || (n == 96) || (n == 128) || (n == 160);
   endfunction
endpackage

// File: rtl/irqagg_addr_dec.sv
module irqagg_addr_dec
   import irqagg_pkg::*;
#(
   parameter int N_CPU  = 2,
   parameter int N_GRP  = 2,
   parameter int CPU_AW = 1,
   parameter int WIN_AW = 3,
   localparam int GRP_AW = WIN_AW - 2
) (
   input  logic [CPU_AW+WIN_AW-1:0] addr,
   output logic [N_CPU-1:0]         cpu_sel,
   output logic [GRP_AW-1:0]        grp,
   output reg_kind_e                kind,
   output logic                     hit
);
   logic [CPU_AW-1:0] cpu_idx;
   logic              cpu_ok;
   logic              grp_ok;

   assign cpu_idx = addr[CPU_AW+WIN_AW-1:WIN_AW];
   assign grp     = addr[WIN_AW-1:2];
   assign kind    = reg_kind_e'(addr[1:0]);
   assign cpu_ok  = ({1'b0, cpu_idx} < (CPU_AW+1)'(N_CPU));
   assign grp_ok  = ({1'b0, grp} < (GRP_AW+1)'(N_GRP));
   assign hit     = cpu_ok && grp_ok;

   for (genvar c = 0; c < N_CPU; c++) begin : g_sel
      assign cpu_sel[c] = hit && (cpu_idx == CPU_AW'(c));
   end
endmodule

// File: rtl/irqagg_cpu_bank.sv
module irqagg_cpu_bank #(
   parameter int N_IRQ = 64,
   localparam int N_GRP = N_IRQ / 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_IRQ-1:0] irq_in,
   input  logic [N_GRP-1:0] set_stb,
   input  logic [N_GRP-1:0] clr_stb,
   input  logic [31:0]      wdata,
   output logic [N_IRQ-1:0] mask_o,
   output logic [N_IRQ-1:0] pend_o,
   output logic             irq_o
);
   for (genvar g = 0; g < N_GRP; g++) begin : g_grp
      logic [31:0] grp_mask;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            grp_mask <= '1;
         end else if (set_stb[g]) begin
            grp_mask <= grp_mask | wdata;
         end else if (clr_stb[g]) begin
            grp_mask <= grp_mask & ~wdata;
         end
      end
      assign mask_o[g*32 +: 32] = grp_mask;
   end

   assign pend_o = irq_in & ~mask_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= |pend_o;
   end
endmodule

// File: rtl/irqagg_read_mux.sv
module irqagg_read_mux
   import irqagg_pkg::*;
#(
   parameter int N_CPU  = 2,
   parameter int N_IRQ  = 64,
   parameter int GRP_AW = 1,
   localparam int N_GRP = N_IRQ / 32
) (
   input  logic [N_CPU-1:0]            cpu_sel,
   input  logic [GRP_AW-1:0]           grp,
   input  reg_kind_e                   kind,
   input  logic [N_CPU-1:0][N_IRQ-1:0] mask_all,
   input  logic [N_CPU-1:0][N_IRQ-1:0] pend_all,
   output logic [31:0]                 word
);
   always_comb begin
      word = '0;
      for (int c = 0; c < N_CPU; c++) begin
         for (int g = 0; g < N_GRP; g++) begin
            if (cpu_sel[c] && (grp == GRP_AW'(g))) begin
               if (kind == RK_STATUS) word = word | pend_all[c][g*32 +: 32];
               if (kind == RK_MASK)   word = word | mask_all[c][g*32 +: 32];
            end
         end
      end
   end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
   import irqagg_pkg::*;
#(
   parameter int N_IRQ = 64,
   parameter int N_CPU = 2,
   localparam int N_GRP  = N_IRQ / 32,
   localparam int WIN_AW = $clog2(4 * N_GRP),
   localparam int GRP_AW = WIN_AW - 2,
   localparam int CPU_AW = (N_CPU > 1) ? $clog2(N_CPU) : 1,
   localparam int ADDR_W = CPU_AW + WIN_AW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_IRQ-1:0]  irq_in,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [N_CPU-1:0]  irq_out
);
   if (!line_count_ok(N_IRQ)) begin : g_bad_lines
      $error("irq_aggregator: N_IRQ must be 64, 96, 128 or 160");
   end
   if (N_CPU < 1) begin : g_bad_cpus
      $error("irq_aggregator: N_CPU must be at least 1");
   end

   logic [N_CPU-1:0]            cpu_sel;
   logic [GRP_AW-1:0]           grp;
   reg_kind_e                   kind;
   logic                        hit;
   logic [N_CPU-1:0][N_IRQ-1:0] mask_all;
   logic [N_CPU-1:0][N_IRQ-1:0] pend_all;
   logic [31:0]                 rd_word;

   irqagg_addr_dec #(
      .N_CPU(N_CPU), .N_GRP(N_GRP), .CPU_AW(CPU_AW), .WIN_AW(WIN_AW)
   ) u_dec (
      .addr(bus_addr), .cpu_sel(cpu_sel), .grp(grp), .kind(kind), .hit(hit)
   );

   for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
      logic [N_GRP-1:0] set_stb;
      logic [N_GRP-1:0] clr_stb;
      for (genvar g = 0; g < N_GRP; g++) begin : g_stb
         logic grp_wr;
         assign grp_wr     = bus_wr && hit && cpu_sel[c] && (grp == GRP_AW'(g));
         assign set_stb[g] = grp_wr && (kind == RK_SET);
         assign clr_stb[g] = grp_wr && (kind == RK_CLEAR);
      end

      irqagg_cpu_bank #(.N_IRQ(N_IRQ)) u_bank (
         .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
         .set_stb(set_stb), .clr_stb(clr_stb), .wdata(bus_wdata),
         .mask_o(mask_all[c]), .pend_o(pend_all[c]), .irq_o(irq_out[c])
      );
   end

   irqagg_read_mux #(
      .N_CPU(N_CPU), .N_IRQ(N_IRQ), .GRP_AW(GRP_AW)
   ) u_rmux (
      .cpu_sel(cpu_sel), .grp(grp), .kind(kind),
      .mask_all(mask_all), .pend_all(pend_all), .word(rd_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_word;
      else             bus_rdata <= '0;
   end
endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker #(
   parameter int N_IRQ  = 64,
   parameter int N_CPU  = 2,
   parameter int ADDR_W = 4,
   parameter int WIN_AW = 3,
   localparam int CPU_AW = ADDR_W - WIN_AW
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [N_IRQ-1:0]            irq_in,
   input logic                        bus_wr,
   input logic                        bus_rd,
   input logic [ADDR_W-1:0]           bus_addr,
   input logic [31:0]                 bus_rdata,
   input logic [N_CPU-1:0]            irq_out,
   input logic [N_CPU-1:0][N_IRQ-1:0] mask_all
);
   p_idle_rdata_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_rd) |-> (bus_rdata == 32'd0));

   for (genvar c = 0; c < N_CPU; c++) begin : g_cpu_chk
      p_masked_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (&$past(mask_all[c])) |-> !irq_out[c]);

      p_no_source_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !(|$past(irq_in)) |-> !irq_out[c]);

      p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(bus_wr) |-> $stable(mask_all[c]));

      p_write_scoped_r7: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(bus_wr) && ($past(bus_addr[ADDR_W-1:WIN_AW]) != CPU_AW'(c)))
            |-> $stable(mask_all[c]));
   end
endmodule

bind irq_aggregator irqagg_checker #(
   .N_IRQ(N_IRQ), .N_CPU(N_CPU), .ADDR_W(ADDR_W), .WIN_AW(WIN_AW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
   .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
   .irq_out(irq_out), .mask_all(mask_all)
);

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;
   localparam int N_IRQ  = 96;
   localparam int N_CPU  = 3;
   localparam int N_GRP  = N_IRQ / 32;
   localparam int WIN_AW = $clog2(4 * N_GRP);
   localparam int CPU_AW = $clog2(N_CPU);
   localparam int ADDR_W = CPU_AW + WIN_AW;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [N_IRQ-1:0]  irq_in = '0;
   logic              bus_wr = 1'b0;
   logic              bus_rd = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [N_CPU-1:0]  irq_out;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   logic [N_IRQ-1:0] m_mask [N_CPU];
   logic [N_IRQ-1:0] m_irq = '0;

   always #2 clk = ~clk;

   irq_aggregator #(.N_IRQ(N_IRQ), .N_CPU(N_CPU)) u_irq_aggregator (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_out(irq_out)
   );

   function automatic bit in_range(int cpu, int off);
      return (cpu < N_CPU) && (off < 4 * N_GRP);
   endfunction

   function automatic logic [31:0] exp_read(int cpu, int off);
      logic [N_IRQ-1:0] st;
      if (!in_range(cpu, off)) return 32'd0;
      st = m_irq & ~m_mask[cpu];
      case (off % 4)
         0:       return st[(off/4)*32 +: 32];
         3:       return m_mask[cpu][(off/4)*32 +: 32];
         default: return 32'd0;
      endcase
   endfunction

   function automatic string auto_tag(int cpu, int off);
      if (!in_range(cpu, off)) return "R8";
      if (off % 4 == 0) return "R2";
      return "R5";
   endfunction

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // Entered at a falling edge; returns at the next falling edge.
   task automatic step(bit wr, bit rd, int cpu, int off, logic [31:0] d, string tag);
      logic [31:0]      e_rd;
      logic [N_CPU-1:0] e_irq;
      bus_wr    = wr;
      bus_rd    = rd;
      bus_addr  = ADDR_W'(cpu * (1 << WIN_AW) + off);
      bus_wdata = d;
      irq_in    = m_irq;
      e_rd = rd ? exp_read(cpu, off) : 32'd0;
      for (int c = 0; c < N_CPU; c++) e_irq[c] = |(m_irq & ~m_mask[c]);
      @(posedge clk);
      if (wr && in_range(cpu, off)) begin
         if (off % 4 == 1) m_mask[cpu][(off/4)*32 +: 32] |= d;
         if (off % 4 == 2) m_mask[cpu][(off/4)*32 +: 32] &= ~d;
      end
      @(negedge clk);
      if (rd) check((tag == "") ? auto_tag(cpu, off) : tag, bus_rdata, e_rd);
      else    check("R2 idle", bus_rdata, 32'd0);
      check("R6 irq_out", 32'(irq_out), 32'(e_irq));
   endtask

   initial begin
      #(4 * 200000);
      if (!finished) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int c = 0; c < N_CPU; c++) m_mask[c] = '1;
      repeat (3) @(negedge clk);
      // R1: quiet outputs while and after reset
      check("R1 rdata", bus_rdata, 32'd0);
      check("R1 irq_out", 32'(irq_out), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int c = 0; c < N_CPU; c++)
         for (int g = 0; g < N_GRP; g++)
            step(0, 1, c, 4*g + 3, 0, "R1 mask");
      // R1: masked input raises nothing
      m_irq = '1;
      step(0, 0, 0, 0, 0, "");
      step(0, 1, 2, 4, 0, "R1 status");
      m_irq = '0;

      // R3: zero data sets nothing; ones set
      step(1, 0, 1, 2, 32'hFFFF_FFFF, "");
      step(1, 0, 1, 1, 32'h0, "");
      step(0, 1, 1, 3, 0, "R3 zero");
      step(1, 0, 1, 1, 32'h0000_00F0, "");
      step(0, 1, 1, 3, 0, "R3 set");
      // R4: zero data clears nothing; ones clear
      step(1, 0, 1, 2, 32'h0, "");
      step(0, 1, 1, 3, 0, "R4 zero");
      step(1, 0, 1, 2, 32'h0000_0030, "");
      step(0, 1, 1, 3, 0, "R4 clear");
      // R6: source routed to CPU1 only
      step(1, 0, 1, 6, 32'h0000_0100, "");
      m_irq[32+8] = 1'b1;
      step(0, 0, 0, 0, 0, "");
      step(0, 1, 1, 4, 0, "R6 status");
      // R9: drop the source, status and irq fall
      m_irq[32+8] = 1'b0;
      step(0, 1, 1, 4, 0, "R9 status");
      step(0, 1, 1, 4, 0, "R9 status");
      // R5: writes to status and mask words ignored; set/clear read zero
      step(1, 0, 1, 3, 32'h0, "");
      step(1, 0, 1, 0, 32'hFFFF_FFFF, "");
      step(0, 1, 1, 3, 0, "R5 mask");
      step(0, 1, 1, 1, 0, "R5 set reads 0");
      step(0, 1, 1, 2, 0, "R5 clear reads 0");
      // R7: writes to CPU0 leave CPU1 alone
      step(1, 0, 0, 2, 32'hFFFF_FFFF, "");
      step(0, 1, 1, 3, 0, "R7 other cpu");
      step(0, 1, 0, 3, 0, "R7 own cpu");
      // R8: holes and missing window
      step(0, 1, 3, 3, 0, "R8 no cpu");
      step(0, 1, 0, 13, 0, "R8 hole");
      step(1, 0, 3, 2, 32'hFFFF_FFFF, "");
      step(1, 0, 2, 14, 32'hFFFF_FFFF, "");
      for (int c = 0; c < N_CPU; c++)
         for (int g = 0; g < N_GRP; g++)
            step(0, 1, c, 4*g + 3, 0, "R8 masks kept");

      // Constrained random traffic
      for (int i = 0; i < 4000; i++) begin
         int cpu;
         int off;
         logic [31:0] d;
         if ($urandom_range(0, 3) == 0)
            for (int w = 0; w < N_GRP; w++)
               m_irq[w*32 +: 32] = $urandom & $urandom;
         cpu = $urandom_range(0, 3);
         off = $urandom_range(0, 15);
         if ($urandom_range(0, 2) != 0) off = 4 * $urandom_range(0, N_GRP - 1) + $urandom_range(0, 3);
         d = $urandom;
         if ($urandom_range(0, 1) == 1) d = d & $urandom;
         step($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, cpu, off, d, "");
      end

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule